// File: doc/BRIEF.md
# Multichannel Return-to-Zero Pulser Gate Control

This block is the digital front end of a multichannel return-to-zero transmit pulser. Each channel has two active-high request inputs, one asking for a positive drive and one for a negative drive. The block turns each pair into three gate enables: the high-side switch, the low-side switch, and a damping switch that ties the output to ground. A global output enable overrides everything and turns every switch off.

The requests either go straight through to the decode (transparent mode) or are sampled on rising edges of a re-timing clock (registered mode). The block chooses the mode by itself. A presence detector, clocked by the free-running system clock, watches the re-timing clock input. A re-timing clock held statically high leaves the block transparent. A running re-timing clock moves it to registered mode.

A mode change waits until every held request is zero, so the hand-over happens while all channels sit in the damping state. The re-timing clock is brought into the system-clock domain through a synchronizer, and the held requests are loaded on each detected rising edge.

Top module: `pulse_gate_ctrl`

## Requirements
- R1: With the output enabled, a channel whose positive request is 1 and negative request is 0 asserts only its high-side enable.
- R2: With the output enabled, a channel whose negative request is 1 and positive request is 0 asserts only its low-side enable.
- R3: With the output enabled, a channel whose two requests are both 0 asserts only its damping enable.
- R4: A channel whose two requests are both 1 asserts none of its three enables.
- R5: When outEnable is 0, every enable of every channel is 0, whatever the requests and mode are.
- R6: In transparent mode (retimeActive = 0), the enables follow the request inputs combinationally, in the same cycle.
- R7: In registered mode (retimeActive = 1), request changes have no effect on the enables until the next rising edge of retimeClk. The new value then appears within six system-clock cycles of that edge.
- R8: Two rising edges of retimeClk no more than WIN_CYCLES system-clock cycles apart declare the re-timing clock present. retimeActive then becomes 1, provided the held requests are zero.
- R9: If no rising edge of retimeClk is seen for LOSS_CYCLES system-clock cycles, the clock is declared absent. Once the held requests are zero, retimeActive returns to 0.
- R10: retimeActive changes only while every channel's held requests are zero. A clock that starts or stops while a held request is non-zero leaves the mode unchanged.
- R11: In every cycle, each channel asserts at most one of its three enables.
- R12: After reset, the held requests are zero and retimeActive is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Free-running system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| retimeClk | input | 1 | Re-timing clock; held high selects transparent mode |
| outEnable | input | 1 | Global output enable, active high |
| posReq | input | CHANNELS | Positive-drive request per channel |
| negReq | input | CHANNELS | Negative-drive request per channel |
| hiSideEn | output | CHANNELS | High-side switch enable per channel |
| loSideEn | output | CHANNELS | Low-side switch enable per channel |
| dampEn | output | CHANNELS | Damping switch enable per channel |
| retimeActive | output | 1 | 1 while registered mode is in force |

## Verification
In transparent mode, 256 request patterns are swept with the output enabled, and a shorter sweep is run with it disabled. Across the channels, these patterns hit every request pair, so a crossed decode term, a missing override or a wrong both-high case each shows up on a specific channel.

In registered mode, several patterns are applied and checked just before and just after a re-timing edge. This separates true sampling from pass-through.

Mode changes are tried in four situations: a clock that starts with idle requests, a clock that starts with a request held non-zero, a clock that stops with a request held non-zero, and a clock that stops with idle requests. These tell the presence window, the loss timeout and the idle gate on the mode change apart.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef struct packed {
    logic captureEdge;
    logic useHeld;
  } pgcStrobes_t;
endpackage

// File: rtl/pgc_retime_monitor.sv
module pgc_retime_monitor
  import pgc_pkg::*;
#(
  parameter int WIN_CYCLES  = 40,
  parameter int LOSS_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        retimeClk,
  input  logic        heldIdle,
  output pgcStrobes_t strobes,
  output logic        retimeActive
);
  localparam int CW = $clog2(LOSS_CYCLES + 1);
  localparam logic [CW-1:0] LOSS_LIM = CW'(LOSS_CYCLES);
  localparam logic [CW-1:0] WIN_LIM  = CW'(WIN_CYCLES);

  // synchronizer plus one history stage; reset high so a held-high input makes no edge
  logic [SYNC_STAGES:0] syncChain;
  logic                 riseSeen;
  logic [CW-1:0]        sinceEdge;
  logic                 seenEdge;
  logic                 clkPresent;
  logic                 modeReg;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], retimeClk};
  end

  assign riseSeen = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      sinceEdge  <= LOSS_LIM;
      seenEdge   <= 1'b0;
      clkPresent <= 1'b0;
    end else if (riseSeen) begin
      if (seenEdge && (sinceEdge <= WIN_LIM)) clkPresent <= 1'b1;
      seenEdge  <= 1'b1;
      sinceEdge <= '0;
    end else if (sinceEdge >= LOSS_LIM) begin
      clkPresent <= 1'b0;
      seenEdge   <= 1'b0;
    end else begin
      sinceEdge <= sinceEdge + 1'b1;
    end
  end

  // mode follows presence only while all held requests are idle
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                               modeReg <= 1'b0;
    else if (heldIdle && (modeReg != clkPresent)) modeReg <= clkPresent;
  end

  assign strobes.captureEdge = riseSeen;
  assign strobes.useHeld     = modeReg;
  assign retimeActive        = modeReg;
endmodule

// File: rtl/pgc_gate_decode.sv
module pgc_gate_decode (
  input  logic enable,
  input  logic posBit,
  input  logic negBit,
  output logic hiOn,
  output logic loOn,
  output logic dampOn
);
  always_comb begin
    hiOn   = 1'b0;
    loOn   = 1'b0;
    dampOn = 1'b0;
    if (enable) begin
      unique case ({posBit, negBit})
        2'b10:   hiOn   = 1'b1;
        2'b01:   loOn   = 1'b1;
        2'b00:   dampOn = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pgc_channel_path.sv
module pgc_channel_path
  import pgc_pkg::*;
#(
  parameter int CHANNELS = 8
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  pgcStrobes_t         strobes,
  input  logic                outEnable,
  input  logic [CHANNELS-1:0] posReq,
  input  logic [CHANNELS-1:0] negReq,
  output logic [CHANNELS-1:0] hiSideEn,
  output logic [CHANNELS-1:0] loSideEn,
  output logic [CHANNELS-1:0] dampEn,
  output logic                heldIdle
);
  logic [CHANNELS-1:0] heldPos, heldNeg;
  logic [CHANNELS-1:0] selPos, selNeg;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      heldPos <= '0;
      heldNeg <= '0;
    end else if (strobes.captureEdge) begin
      heldPos <= posReq;
      heldNeg <= negReq;
    end
  end

  assign heldIdle = ~|{heldPos, heldNeg};
  assign selPos   = strobes.useHeld ? heldPos : posReq;
  assign selNeg   = strobes.useHeld ? heldNeg : negReq;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    pgc_gate_decode u_dec (
      .enable (outEnable),
      .posBit (selPos[ch]),
      .negBit (selNeg[ch]),
      .hiOn   (hiSideEn[ch]),
      .loOn   (loSideEn[ch]),
      .dampOn (dampEn[ch])
    );
  end
endmodule

// File: rtl/pulse_gate_ctrl.sv
module pulse_gate_ctrl
  import pgc_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int WIN_CYCLES  = 40,
  parameter int LOSS_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                retimeClk,
  input  logic                outEnable,
  input  logic [CHANNELS-1:0] posReq,
  input  logic [CHANNELS-1:0] negReq,
  output logic [CHANNELS-1:0] hiSideEn,
  output logic [CHANNELS-1:0] loSideEn,
  output logic [CHANNELS-1:0] dampEn,
  output logic                retimeActive
);
  pgcStrobes_t strobes;
  logic        heldIdle;

  pgc_retime_monitor #(
    .WIN_CYCLES  (WIN_CYCLES),
    .LOSS_CYCLES (LOSS_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mon (
    .sysClk       (sysClk),
    .rstN         (rstN),
    .retimeClk    (retimeClk),
    .heldIdle     (heldIdle),
    .strobes      (strobes),
    .retimeActive (retimeActive)
  );

  pgc_channel_path #(.CHANNELS(CHANNELS)) u_path (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .strobes   (strobes),
    .outEnable (outEnable),
    .posReq    (posReq),
    .negReq    (negReq),
    .hiSideEn  (hiSideEn),
    .loSideEn  (loSideEn),
    .dampEn    (dampEn),
    .heldIdle  (heldIdle)
  );
endmodule

// File: rtl/pulse_gate_ctrl_chk.sv
module pulse_gate_ctrl_chk #(
  parameter int CHANNELS = 8
) (
  input logic                sysClk,
  input logic                rstN,
  input logic                outEnable,
  input logic [CHANNELS-1:0] posReq,
  input logic [CHANNELS-1:0] negReq,
  input logic [CHANNELS-1:0] hiSideEn,
  input logic [CHANNELS-1:0] loSideEn,
  input logic [CHANNELS-1:0] dampEn,
  input logic                retimeActive,
  input logic                heldIdle
);
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_mutex
    AST_ONE_SWITCH: assert property (@(posedge sysClk) disable iff (!rstN)
      $onehot0({hiSideEn[ch], loSideEn[ch], dampEn[ch]})); // R11
  end

  AST_DISABLE_ALL_OFF: assert property (@(posedge sysClk) disable iff (!rstN)
    !outEnable |-> ((hiSideEn | loSideEn | dampEn) == '0)); // R5

  AST_MODE_IDLE_SWITCH: assert property (@(posedge sysClk) disable iff (!rstN)
    (retimeActive != $past(retimeActive)) |-> $past(heldIdle)); // R10

  AST_PASS_THROUGH_HI: assert property (@(posedge sysClk) disable iff (!rstN)
    (!retimeActive && outEnable) |-> (hiSideEn == (posReq & ~negReq))); // R6

  AST_RTZ_IDLE: assert property (@(posedge sysClk) disable iff (!rstN)
    (!retimeActive && outEnable && posReq == '0 && negReq == '0) |-> (dampEn == '1)); // R3
endmodule

bind pulse_gate_ctrl pulse_gate_ctrl_chk #(.CHANNELS(CHANNELS)) u_chk (
  .sysClk       (sysClk),
  .rstN         (rstN),
  .outEnable    (outEnable),
  .posReq       (posReq),
  .negReq       (negReq),
  .hiSideEn     (hiSideEn),
  .loSideEn     (loSideEn),
  .dampEn       (dampEn),
  .retimeActive (retimeActive),
  .heldIdle     (heldIdle)
);

// File: tb/pulse_gate_ctrl_bench.sv
module pulse_gate_ctrl_bench;
  localparam int CH   = 8;
  localparam int LOSS = 64;

  logic          sysClk = 1'b0;
  logic          rstN;
  logic          retimeClk;
  logic          outEnable;
  logic [CH-1:0] posReq, negReq;
  logic [CH-1:0] hiSideEn, loSideEn, dampEn;
  logic          retimeActive;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  always #5 sysClk = ~sysClk;

  pulse_gate_ctrl #(.CHANNELS(CH), .WIN_CYCLES(40), .LOSS_CYCLES(LOSS)) u_pulse_gate_ctrl (
    .sysClk(sysClk), .rstN(rstN), .retimeClk(retimeClk), .outEnable(outEnable),
    .posReq(posReq), .negReq(negReq), .hiSideEn(hiSideEn), .loSideEn(loSideEn),
    .dampEn(dampEn), .retimeActive(retimeActive));

  task automatic waitCyc(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  // check all enables against arithmetic expectation from (oe, p, n)
  task automatic checkOut(input string req, input logic oe, input logic [CH-1:0] p,
                          input logic [CH-1:0] n);
    logic [CH-1:0] eh, el, ed;
    #1;
    eh = oe ? (p & ~n) : '0;
    el = oe ? (n & ~p) : '0;
    ed = oe ? (~p & ~n) : '0;
    vectors++;
    if (hiSideEn !== eh || loSideEn !== el || dampEn !== ed) begin
      errors++;
      $display("FAIL %s: hi=%b lo=%b damp=%b expected hi=%b lo=%b damp=%b",
               req, hiSideEn, loSideEn, dampEn, eh, el, ed);
    end
    for (int c = 0; c < CH; c++) begin
      if ($countones({hiSideEn[c], loSideEn[c], dampEn[c]}) > 1) begin
        errors++;
        $display("FAIL R11: channel %0d enables %b expected at most one",
                 c, {hiSideEn[c], loSideEn[c], dampEn[c]});
      end
    end
  endtask

  task automatic checkMode(input string req, input logic exp);
    #1;
    vectors++;
    if (retimeActive !== exp) begin
      errors++;
      $display("FAIL %s: retimeActive=%b expected %b", req, retimeActive, exp);
    end
  endtask

  task automatic retimePulse();
    retimeClk = 1'b0;
    waitCyc(8);
    retimeClk = 1'b1;
    waitCyc(8);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [CH-1:0] prevP, prevN;
    rstN = 1'b0; retimeClk = 1'b1; outEnable = 1'b1; posReq = '0; negReq = '0;
    waitCyc(3);
    // R12: reset state, transparent and all damping
    checkMode("R12", 1'b0);
    checkOut("R12", 1'b1, '0, '0);
    rstN = 1'b1;
    waitCyc(2);

    // R1 R2 R3 R4 R6: transparent sweep, patterns cover every request pair per channel
    for (int v = 0; v < 256; v++) begin
      posReq = CH'(v);
      negReq = CH'((v * 37 + 11) % 256);
      checkOut("R1/R2/R3/R4/R6", 1'b1, posReq, negReq);
      waitCyc(1);
    end
    // R5: disable overrides everything
    outEnable = 1'b0;
    for (int v = 0; v < 32; v++) begin
      posReq = CH'(v * 9);
      negReq = CH'(v * 23 + 5);
      checkOut("R5", 1'b0, posReq, negReq);
      waitCyc(1);
    end
    outEnable = 1'b1;

    // R10: clock starting while a request is held non-zero keeps transparent mode
    posReq = 8'h11; negReq = 8'h02;
    for (int k = 0; k < 4; k++) retimePulse();
    checkMode("R10", 1'b0);
    checkOut("R10", 1'b1, posReq, negReq);

    // R8: idle requests, running clock -> registered mode
    posReq = '0; negReq = '0;
    for (int k = 0; k < 3; k++) retimePulse();
    checkMode("R8", 1'b1);

    // R7: registered sampling, checked before and after an edge
    prevP = '0; prevN = '0;
    for (int k = 0; k < 6; k++) begin
      retimeClk = 1'b0;
      posReq = CH'(8'hA5 ^ (k * 29));
      negReq = CH'(8'h3C ^ (k * 71));
      waitCyc(6);
      checkOut("R7", 1'b1, prevP, prevN);
      retimeClk = 1'b1;
      waitCyc(6);
      checkOut("R7", 1'b1, posReq, negReq);
      prevP = posReq; prevN = negReq;
      waitCyc(2);
      // R5 in registered mode
      outEnable = 1'b0;
      checkOut("R5", 1'b0, prevP, prevN);
      outEnable = 1'b1;
    end

    // R10: clock stopping with a non-zero held request keeps registered mode
    waitCyc(LOSS + 20);
    checkMode("R10", 1'b1);
    posReq = '0; negReq = 8'hFF;
    checkOut("R10", 1'b1, prevP, prevN);

    // R9: return requests to zero with one edge, then stop the clock
    posReq = '0; negReq = '0;
    retimePulse();
    retimePulse();
    waitCyc(LOSS + 20);
    checkMode("R9", 1'b0);
    posReq = 8'h0F; negReq = 8'h30;
    checkOut("R9", 1'b1, posReq, negReq);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule